// File: doc/BRIEF.md
# Four-Digit Code Entry Panel

This datapath gathers a four-digit decimal access code from two sources, a decoded keypad (a four-bit code with a valid strobe) and a bank of ten slide switches, and gives the user feedback. Digits are kept in the order they arrive. The first digit appears on the leftmost of four common-anode seven-segment displays, and each display updates in the cycle after its digit arrives. The held code is compared against a code fixed by a parameter, and the result goes back to the sequencing controller as a match flag.

A separate sequencing FSM owns the control decisions. It sends this block level and pulse controls: clear, end of verification, inactivity timeout, wrong attempt, access granted, lockout, and the idle and granted state levels. From these the block wipes its digit store, counts failed attempts on a thermometer LED bar, lights the status LEDs, and runs a buzzer for a fixed number of cycles on each alarm event.

Top module: `code_entry_panel`

## Requirements
- R1: Accepted digits are stored in arrival order. Display position p (p = 0 is leftmost, driven on `seg_n[7*(3-p)+6 : 7*(3-p)]`) shows the p-th digit from the clock edge that accepts it. Each 7-bit field is ordered {g,f,e,d,c,b,a} with segment a in bit 0 and is active low. The lit-segment patterns for 0..9 are 3F,06,5B,4F,66,6D,7D,07,7F,6F (hex, active-high form).
- R2: A display position with no digit is blank (all seven bits 1). After reset all positions are blank and `entry_count` is 0.
- R3: Once four digits are held, further digits are ignored and `entry_count` stays at 4.
- R4: A keypad strobe with a code 0..9 enters that digit. Codes 10..15 are ignored. Switch n enters digit n only on its off-to-on transition, so a held switch enters once. If several switches rise together, the lowest index wins. A keypad digit in the same cycle takes precedence over any switch.
- R5: A pulse on `clear_req`, `verify_done` or `timeout_evt` empties the store at that edge, and takes priority over a digit arriving in the same cycle.
- R6: While `lockout_active` is high, no digit is accepted from either source.
- R7: `match` is 1 only when exactly four digits are held and they equal the parameter code, whose first digit sits in the top nibble.
- R8: `led_fail` is a thermometer (bit 0 lights first). It counts `deny_evt` pulses, saturates at three, and clears on `grant_evt` or when `lockout_active` falls.
- R9: `buzzer` is high for exactly BEEP_CYCLES cycles after a `deny_evt`, a `timeout_evt` or the rise of `lockout_active`. A new event during a beep restarts the full duration.
- R10: `led_idle_lock` equals `st_idle` OR `lockout_active`, and `led_grant` equals `st_granted`, with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_valid | input | 1 | Keypad digit strobe |
| key_code | input | 4 | Decoded keypad code |
| sw | input | 10 | Slide switches, one per digit |
| clear_req | input | 1 | User clear pulse |
| verify_done | input | 1 | End-of-verification pulse |
| timeout_evt | input | 1 | Inactivity timeout pulse |
| deny_evt | input | 1 | Wrong-attempt pulse |
| grant_evt | input | 1 | Access-granted pulse |
| lockout_active | input | 1 | Lockout level from the controller |
| st_idle | input | 1 | Controller idle state level |
| st_granted | input | 1 | Controller granted state level |
| seg_n | output | 28 | Four active-low seven-segment fields, leftmost in the top bits |
| entry_count | output | 3 | Number of digits held |
| match | output | 1 | Held code equals the stored code |
| led_idle_lock | output | 1 | Idle-or-locked LED |
| led_grant | output | 1 | Access LED |
| led_fail | output | 3 | Failed-attempt thermometer |
| buzzer | output | 1 | Buzzer enable |

## Verification
A corrupted digit register or write pointer shows on `seg_n` one clock edge after the digit that exposes it: the wrong glyph, a gap, or a digit in the wrong slot. A stuck count shows on `entry_count` in the same cycle. A wrong switch edge register shows as a repeated or missing digit when a switch is held or released. A faulty beep counter shows as a buzzer pulse that is one or more cycles off its length, so every beep is timed cycle by cycle. The failed-attempt counter is checked against each saturation and release event.

// File: rtl/entry_pkg.sv
// Shared constants and the seven-segment glyph function for the code entry panel.
// Assumes decimal digits only; codes above 9 yield a blank glyph.
package entry_pkg;
    localparam int SEG_W = 7;

    // Active-high glyph {g,f,e,d,c,b,a} for one decimal digit.
    function automatic logic [SEG_W-1:0] glyph(input logic [3:0] d);
        logic [SEG_W-1:0] g;
        case (d)
            4'd0: g = 7'h3F;
            4'd1: g = 7'h06;
            4'd2: g = 7'h5B;
            4'd3: g = 7'h4F;
            4'd4: g = 7'h66;
            4'd5: g = 7'h6D;
            4'd6: g = 7'h7D;
            4'd7: g = 7'h07;
            4'd8: g = 7'h7F;
            4'd9: g = 7'h6F;
            default: g = 7'h00;
        endcase
        return g;
    endfunction
endpackage

// File: rtl/digit_source_merge.sv
// Merges the keypad and the slide switches into one digit strobe.
// Keypad codes 0..9 win. Otherwise the lowest-index switch with a rising edge
// supplies the digit. Switch history resets to all-off.
module digit_source_merge #(
    parameter int SW_N = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            key_valid,
    input  logic [3:0]      key_code,
    input  logic [SW_N-1:0] sw,
    output logic            dig_valid,
    output logic [3:0]      dig_val
);
    logic [SW_N-1:0] sw_q;
    logic [SW_N-1:0] rise;
    logic            sw_hit;
    logic [3:0]      sw_idx;
    logic            key_ok;

    // Remember last switch levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sw_q <= '0;
        else        sw_q <= sw;
    end

    assign rise   = sw & ~sw_q;
    assign key_ok = key_valid && (key_code <= 4'd9);

    // Pick the lowest rising switch index.
    always_comb begin
        sw_hit = 1'b0;
        sw_idx = '0;
        for (int i = SW_N - 1; i >= 0; i--) begin
            if (rise[i]) begin
                sw_hit = 1'b1;
                sw_idx = 4'(i);
            end
        end
    end

    // Keypad precedence over the switches.
    always_comb begin
        dig_valid = key_ok || sw_hit;
        dig_val   = key_ok ? key_code : sw_idx;
    end
endmodule

// File: rtl/digit_store.sv
// Ordered store for up to N decimal digits with a code comparator.
// Digit p sits at nibble [4*(N-1-p) +: 4], the same layout as CODE.
// A wipe wins over a new digit, and a hold blocks entry.
module digit_store #(
    parameter int          N    = 4,
    parameter logic [15:0] CODE = 16'h1234,
    localparam int         CW   = $clog2(N + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           dig_valid,
    input  logic [3:0]     dig_val,
    input  logic           wipe,
    input  logic           hold,
    output logic [CW-1:0]  count,
    output logic [4*N-1:0] digits,
    output logic           match
);
    logic [CW-1:0]  cnt_q;
    logic [4*N-1:0] dig_q;

    // Append digits in order, and empty the store on wipe.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe) begin
            cnt_q <= '0;
            dig_q <= '0;
        end else if (dig_valid && !hold && cnt_q < CW'(N)) begin
            dig_q[4*(N-1-int'(cnt_q)) +: 4] <= dig_val;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count  = cnt_q;
    assign digits = dig_q;
    assign match  = (cnt_q == CW'(N)) && (dig_q == CODE[4*N-1:0]);
endmodule

// File: rtl/feedback_ctrl.sv
// Failed-attempt counter (saturating at 3, shown as a thermometer) and buzzer timer.
// Assumes event inputs are single-cycle pulses; lockout is a level.
module feedback_ctrl #(
    parameter int  BEEP_CYCLES = 5_000_000,
    localparam int BW          = $clog2(BEEP_CYCLES + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       deny_evt,
    input  logic       grant_evt,
    input  logic       timeout_evt,
    input  logic       lockout_active,
    output logic [2:0] led_fail,
    output logic       buzzer
);
    logic          lock_q;
    logic [1:0]    fail_q;
    logic [BW-1:0] beep_q;
    logic          alarm;

    // Lockout level history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lock_q <= 1'b0;
        else        lock_q <= lockout_active;
    end

    assign alarm = deny_evt || timeout_evt || (lockout_active && !lock_q);

    // Failed-attempt count: clear on grant or on lockout release.
    always_ff @(posedge clk) begin
        if (!rst_n || grant_evt || (!lockout_active && lock_q)) fail_q <= '0;
        else if (deny_evt && fail_q != 2'd3)                   fail_q <= fail_q + 1'b1;
    end

    // Buzzer duration counter, reloaded by each alarm event.
    always_ff @(posedge clk) begin
        if (!rst_n)              beep_q <= '0;
        else if (alarm)          beep_q <= BW'(BEEP_CYCLES);
        else if (beep_q != '0)   beep_q <= beep_q - 1'b1;
    end

    assign buzzer   = (beep_q != '0);
    assign led_fail = {fail_q == 2'd3, fail_q != 2'd0 && fail_q != 2'd1, fail_q != 2'd0};
endmodule

// File: rtl/code_entry_panel.sv
// Top of the code entry panel: digit sources, ordered store, active-low displays,
// status LEDs and buzzer. Controls come from an external sequencing FSM.
// The leftmost display (first digit) drives the top seven bits of seg_n.
module code_entry_panel #(
    parameter int          N           = 4,
    parameter logic [15:0] CODE        = 16'h1234,
    parameter int          SW_N        = 10,
    parameter int          BEEP_CYCLES = 5_000_000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     key_valid,
    input  logic [3:0]               key_code,
    input  logic [SW_N-1:0]          sw,
    input  logic                     clear_req,
    input  logic                     verify_done,
    input  logic                     timeout_evt,
    input  logic                     deny_evt,
    input  logic                     grant_evt,
    input  logic                     lockout_active,
    input  logic                     st_idle,
    input  logic                     st_granted,
    output logic [7*N-1:0]           seg_n,
    output logic [$clog2(N+1)-1:0]   entry_count,
    output logic                     match,
    output logic                     led_idle_lock,
    output logic                     led_grant,
    output logic [2:0]               led_fail,
    output logic                     buzzer
);
    import entry_pkg::*;

    localparam int CW = $clog2(N + 1);

    logic           dig_valid;
    logic [3:0]     dig_val;
    logic [4*N-1:0] digits;
    logic [CW-1:0]  count;

    digit_source_merge #(.SW_N(SW_N)) u_src (
        .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_code(key_code),
        .sw(sw), .dig_valid(dig_valid), .dig_val(dig_val)
    );

    digit_store #(.N(N), .CODE(CODE)) u_store (
        .clk(clk), .rst_n(rst_n), .dig_valid(dig_valid), .dig_val(dig_val),
        .wipe(clear_req || verify_done || timeout_evt), .hold(lockout_active),
        .count(count), .digits(digits), .match(match)
    );

    feedback_ctrl #(.BEEP_CYCLES(BEEP_CYCLES)) u_fb (
        .clk(clk), .rst_n(rst_n), .deny_evt(deny_evt), .grant_evt(grant_evt),
        .timeout_evt(timeout_evt), .lockout_active(lockout_active),
        .led_fail(led_fail), .buzzer(buzzer)
    );

    // One active-low decoder per display position; empty positions are blank.
    for (genvar p = 0; p < N; p++) begin : g_disp
        assign seg_n[SEG_W*(N-1-p) +: SEG_W] =
            (count > CW'(p)) ? ~glyph(digits[4*(N-1-p) +: 4]) : {SEG_W{1'b1}};
    end

    assign entry_count   = count;
    assign led_idle_lock = st_idle || lockout_active;
    assign led_grant     = st_granted;
endmodule

// File: rtl/entry_panel_checker.sv
// Temporal checks on the code entry panel ports, bound into every instance.
module entry_panel_checker #(
    parameter int N = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   clear_req,
    input logic                   verify_done,
    input logic                   timeout_evt,
    input logic                   deny_evt,
    input logic                   lockout_active,
    input logic [7*N-1:0]         seg_n,
    input logic [$clog2(N+1)-1:0] entry_count,
    input logic                   match,
    input logic [2:0]             led_fail,
    input logic                   buzzer
);
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        entry_count <= ($clog2(N+1))'(N));

    assert_wipe_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_req || verify_done || timeout_evt) |=> (entry_count == '0 && &seg_n));

    assert_lock_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lockout_active && !clear_req && !verify_done && !timeout_evt) |=> $stable(entry_count));

    assert_match_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> entry_count == ($clog2(N+1))'(N));

    assert_fail_thermo_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!led_fail[1] || led_fail[0]) && (!led_fail[2] || led_fail[1]));

    assert_deny_beeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        deny_evt |=> buzzer);
endmodule

bind code_entry_panel entry_panel_checker #(.N(N)) u_chk (
    .clk(clk), .rst_n(rst_n), .clear_req(clear_req), .verify_done(verify_done),
    .timeout_evt(timeout_evt), .deny_evt(deny_evt), .lockout_active(lockout_active),
    .seg_n(seg_n), .entry_count(entry_count), .match(match),
    .led_fail(led_fail), .buzzer(buzzer)
);

// File: tb/sim_code_entry_panel.sv
// Self-checking bench: digit sweeps over both sources, ordering, wipe, lockout,
// match, failed-attempt bar, buzzer timing and status LEDs.
module sim_code_entry_panel;
    localparam int BEEP = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       key_valid = 1'b0;
    logic [3:0] key_code = '0;
    logic [9:0] sw = '0;
    logic       clear_req = 1'b0, verify_done = 1'b0, timeout_evt = 1'b0;
    logic       deny_evt = 1'b0, grant_evt = 1'b0, lockout_active = 1'b0;
    logic       st_idle = 1'b0, st_granted = 1'b0;
    logic [27:0] seg_n;
    logic [2:0] entry_count;
    logic       match, led_idle_lock, led_grant, buzzer;
    logic [2:0] led_fail;

    int checks = 0;
    int errors = 0;
    int mbuf[4];
    int mcnt = 0;
    bit done = 0;

    code_entry_panel #(.BEEP_CYCLES(BEEP)) u0 (
        .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_code(key_code), .sw(sw),
        .clear_req(clear_req), .verify_done(verify_done), .timeout_evt(timeout_evt),
        .deny_evt(deny_evt), .grant_evt(grant_evt), .lockout_active(lockout_active),
        .st_idle(st_idle), .st_granted(st_granted), .seg_n(seg_n),
        .entry_count(entry_count), .match(match), .led_idle_lock(led_idle_lock),
        .led_grant(led_grant), .led_fail(led_fail), .buzzer(buzzer)
    );

    always #5 clk = ~clk;

    task automatic cyc;
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] pat(input int d);
        logic [6:0] t [10] = '{7'h3F,7'h06,7'h5B,7'h4F,7'h66,7'h6D,7'h7D,7'h07,7'h7F,7'h6F};
        return t[d];
    endfunction

    function automatic logic [27:0] exp_seg();
        logic [27:0] v = '1;
        for (int p = 0; p < 4; p++)
            if (p < mcnt) v[7*(3-p) +: 7] = ~pat(mbuf[p]);
        return v;
    endfunction

    function automatic bit exp_match();
        return mcnt == 4 && mbuf[0] == 1 && mbuf[1] == 2 && mbuf[2] == 3 && mbuf[3] == 4;
    endfunction

    task automatic model_add(input int d);
        if (!lockout_active && mcnt < 4) begin
            mbuf[mcnt] = d;
            mcnt++;
        end
    endtask

    task automatic chk_disp(input string req);
        chk(seg_n == exp_seg(), req, seg_n, exp_seg());
        chk(entry_count == 3'(mcnt), req, entry_count, mcnt);
        chk(match == exp_match(), req, match, exp_match());
    endtask

    task automatic key(input int d);
        key_valid = 1'b1; key_code = 4'(d);
        cyc;
        key_valid = 1'b0;
        if (d <= 9) model_add(d);
    endtask

    task automatic swp(input int n);
        sw[n] = 1'b1; cyc; model_add(n);
        chk_disp("R4 switch rise");
        sw[n] = 1'b0; cyc;
        chk_disp("R4 switch fall no entry");
    endtask

    task automatic wipe(input int which);
        if (which == 0) clear_req = 1'b1;
        else if (which == 1) verify_done = 1'b1;
        else timeout_evt = 1'b1;
        cyc;
        clear_req = 1'b0; verify_done = 1'b0; timeout_evt = 1'b0;
        mcnt = 0;
        chk_disp("R5 wipe");
    endtask

    task automatic beep_len(input string req);
        for (int i = 0; i < BEEP; i++) begin
            chk(buzzer == 1'b1, req, buzzer, 1);
            cyc;
        end
        chk(buzzer == 1'b0, req, buzzer, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc;
        rst_n = 1'b1;
        cyc;
        // R2 reset state
        chk(seg_n == '1, "R2 reset blank", seg_n, 28'hFFFFFFF);
        chk(entry_count == 0, "R2 reset count", entry_count, 0);
        chk(buzzer == 0 && led_fail == 0, "R9 R8 reset", {buzzer, led_fail}, 0);

        // R1 sweep of every digit, alternating sources, through each position
        for (int d = 0; d < 10; d++) begin
            if (d % 2 == 0) begin key(d); chk_disp("R1 keypad digit"); end
            else swp(d);
            if (mcnt == 4) begin
                key(7); chk_disp("R3 fifth digit ignored");
                swp(2);
                wipe(d % 3);
            end
        end
        wipe(0);

        // R4 held switch, multiple rises, keypad precedence, bad keypad codes
        sw[3] = 1'b1; cyc; model_add(3);
        cyc; cyc; chk_disp("R4 held switch once");
        sw[3] = 1'b0; cyc;
        sw = 10'b0010010100; cyc; model_add(2); chk_disp("R4 lowest switch wins");
        sw = '0; cyc;
        sw[8] = 1'b1; key_valid = 1'b1; key_code = 4'd6; cyc; model_add(6);
        key_valid = 1'b0; chk_disp("R4 keypad precedence");
        sw[8] = 1'b0; cyc;
        for (int c = 10; c < 16; c++) begin key(c); chk_disp("R4 code above 9 ignored"); end
        wipe(0);

        // R7 match cases
        key(1); key(2); key(3); chk_disp("R7 three digits no match");
        key(4); chk_disp("R7 correct code matches");
        wipe(1);
        key(1); key(2); key(3); key(5); chk_disp("R7 wrong last digit");
        wipe(0);
        key(4); key(3); key(2); key(1); chk_disp("R7 reversed order");
        wipe(2);

        // R5 clear beats simultaneous digit
        key(9);
        clear_req = 1'b1; key_valid = 1'b1; key_code = 4'd5; cyc;
        clear_req = 1'b0; key_valid = 1'b0; mcnt = 0;
        chk_disp("R5 clear wins over digit");
        cyc;

        // R9 timeout beep length
        timeout_evt = 1'b1; cyc; timeout_evt = 1'b0;
        beep_len("R9 timeout beep");

        // R8 fail thermometer and R9 restart
        for (int k = 1; k <= 4; k++) begin
            deny_evt = 1'b1; cyc; deny_evt = 1'b0;
            chk(led_fail == ((k >= 3) ? 3'b111 : (k == 2) ? 3'b011 : 3'b001),
                "R8 thermometer", led_fail, k);
        end
        beep_len("R9 deny beep");
        deny_evt = 1'b1; cyc; deny_evt = 1'b0;
        cyc; cyc;
        deny_evt = 1'b1; cyc; deny_evt = 1'b0;
        beep_len("R9 restart on new event");
        grant_evt = 1'b1; cyc; grant_evt = 1'b0;
        chk(led_fail == 0, "R8 grant clears", led_fail, 0);

        // R6 lockout blocks digits; R9 lockout beep; R8 release clears bar
        key(5); key(6);
        deny_evt = 1'b1; cyc; deny_evt = 1'b0;
        lockout_active = 1'b1; cyc;
        for (int i = 0; i < BEEP; i++) begin
            if (i == 0) key(1);
            else if (i == 1) begin sw[4] = 1'b1; cyc; end
            else begin sw[4] = 1'b0; cyc; end
            chk(buzzer == (i < BEEP - 1), "R9 lockout beep", buzzer, i < BEEP - 1);
        end
        chk_disp("R6 no digit during lockout");
        chk(led_fail == 3'b001, "R8 held through lockout", led_fail, 1);
        lockout_active = 1'b0; cyc;
        chk(led_fail == 0, "R8 lockout release clears", led_fail, 0);
        chk(buzzer == 0, "R9 no beep on release", buzzer, 0);
        key(7); chk_disp("R6 entry resumes");
        wipe(0);

        // R10 status LED combinations
        for (int m = 0; m < 8; m++) begin
            st_idle = m[0]; lockout_active = m[1]; st_granted = m[2];
            #1;
            chk(led_idle_lock == (m[0] | m[1]), "R10 idle/lock LED", led_idle_lock, m[0] | m[1]);
            chk(led_grant == m[2], "R10 grant LED", led_grant, m[2]);
        end
        lockout_active = 1'b0;

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule